// File: doc/BRIEF.md
# Significand Rounding Unit With Precision Control

This block takes a raw 64-bit significand with its guard, round and sticky bits. It rounds the value to 24, 53 or 64 significand bits. The target precision and the rounding direction come from a 16-bit control word held inside the block. The same register also holds six exception mask bits, which are presented on their own output. Each result carries three things: the rounded significand with every bit below the chosen precision cleared, a carry flag that tells the exponent logic to add one, and an inexact flag that is set whenever a nonzero bit was discarded.

Operands enter on a valid/ready stream and leave on a second valid/ready stream, with one register stage between them. An operand is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or when its result is taken on the same edge. A result stays on the output pins, unchanged, until `out_ready` takes it. The control word is written through plain pins, and a write applies to operands accepted on later edges.

Top module: `sig_round_unit`

## Requirements
- R1: After reset the control word reads 16'h037F, which means bit 12 is 0, nearest rounding and extended precision. A write with `cw_wr_en` high stores `cw_wr_data` on that edge, and operands accepted from the next edge on use the new value.
- R2: `exc_mask` always equals bits 5 down to 0 of the stored control word.
- R3: Control-word bits 11:10 select the rounding direction: 00 is nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, and 11 truncates toward zero. Truncation never increments.
- R4: Control-word bits 9:8 select the precision: 00 gives 24 bits, 10 gives 53 bits and 11 gives 64 bits. The reserved code 01 behaves exactly like 11.
- R5: In every result, the bits of `out_sig` below the selected precision are zero.
- R6: In nearest mode the kept part is incremented only when the discarded part exceeds one half of a unit in the last place, or when it equals exactly one half and the kept LSB is 1.
- R7: When the result is inexact, rounding toward plus infinity increments only if `in_sign` is 0, and rounding toward minus infinity increments only if `in_sign` is 1.
- R8: `out_inexact` is 1 exactly when any discarded bit is nonzero: a significand bit below the precision, guard, round or sticky.
- R9: When the increment carries out of bit 63, `out_sig` is 64'h8000_0000_0000_0000 and `out_carry` is 1. Otherwise `out_carry` is 0.
- R10: Control-word bit 12 is stored and read back, but it has no effect on any rounding result.
- R11: There is one register stage. `in_ready` = !`out_valid` | `out_ready`. While `out_valid` is high and `out_ready` is low, the result and its flags do not change.
- R12: During reset and after it, `out_valid` is 0 until the first operand has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_wr_en | input | 1 | Control word write strobe |
| cw_wr_data | input | 16 | Control word write value |
| cw_q | output | 16 | Stored control word |
| exc_mask | output | 6 | Exception mask bits of the control word |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand can be accepted |
| in_sign | input | 1 | Sign of the operand |
| in_sig | input | 64 | Unrounded significand |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all further lower bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken by downstream |
| out_sig | output | 64 | Rounded significand, low bits cleared |
| out_carry | output | 1 | Increment overflowed; exponent needs +1 |
| out_inexact | output | 1 | Precision exception flag |

## Verification
The bench targets exact ties at each precision, with both an even and an odd kept LSB. A design that rounds ties away from zero, or tests the wrong bit as the LSB, increments on the even tie. Significands of all ones combined with an increment must come back as a single top bit with the carry flag set. A design that drops the carry returns zero, and one that forgets to renormalize leaves garbage in the low bits. The bench also sends exact operands with a set sign through the directed modes to catch a spurious inexact flag or increment, and it sends the reserved precision code and bit 12 to show that neither changes a result. Random back-pressure tests whether a stalled result holds and whether any operand is lost or duplicated.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_CHOP    = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    PC_SGL  = 2'b00,
    PC_RSV  = 2'b01,
    PC_DBL  = 2'b10,
    PC_EXT  = 2'b11
  } pcode_e;

  localparam int unsigned N_PREC = 3;

  // maps a precision code onto the index of the tail extractor to use
  function automatic int unsigned prec_index(input pcode_e pc);
    case (pc)
      PC_SGL:  return 0;
      PC_DBL:  return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/rnd_ctrl_reg.sv
module rnd_ctrl_reg
  import rnd_pkg::*;
#(
  parameter int unsigned CW_W      = 16,
  parameter int unsigned MASK_W    = 6,
  parameter logic [CW_W-1:0] RESET_VAL = 16'h037F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW_W-1:0] wr_data,
  output logic [CW_W-1:0] cw,
  output rmode_e          rmode,
  output pcode_e          pcode,
  output logic [MASK_W-1:0] masks
);
  localparam int unsigned PC_LSB = 8;
  localparam int unsigned RM_LSB = 10;

  logic [CW_W-1:0] cw_r;

  always_ff @(posedge clk) begin
    if (!rst_n)     cw_r <= RESET_VAL;
    else if (wr_en) cw_r <= wr_data;
  end

  assign cw    = cw_r;
  assign rmode = rmode_e'(cw_r[RM_LSB +: 2]);
  assign pcode = pcode_e'(cw_r[PC_LSB +: 2]);
  assign masks = cw_r[MASK_W-1:0];
endmodule

// File: rtl/rnd_tail_extract.sv
module rnd_tail_extract #(
  parameter int unsigned SIG_W = 64,
  parameter int unsigned KEEP  = 24
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             g_in,
  input  logic             r_in,
  input  logic             s_in,
  output logic [SIG_W-1:0] keep_mask,
  output logic [SIG_W-1:0] unit,
  output logic             lsb,
  output logic             guard,
  output logic             sticky
);
  localparam int unsigned DROP = SIG_W - KEEP;

  assign keep_mask = {SIG_W{1'b1}} << DROP;
  assign unit      = {{(SIG_W-1){1'b0}}, 1'b1} << DROP;
  assign lsb       = sig[DROP];

  generate
    if (DROP == 0) begin : g_full
      assign guard  = g_in;
      assign sticky = r_in | s_in;
    end else if (DROP == 1) begin : g_one
      assign guard  = sig[0];
      assign sticky = g_in | r_in | s_in;
    end else begin : g_many
      assign guard  = sig[DROP-1];
      assign sticky = (|sig[DROP-2:0]) | g_in | r_in | s_in;
    end
  endgenerate
endmodule

// File: rtl/rnd_round_core.sv
module rnd_round_core
  import rnd_pkg::*;
#(
  parameter int unsigned SIG_W = 64
) (
  input  logic             sign,
  input  rmode_e           rmode,
  input  logic [SIG_W-1:0] sig,
  input  logic [SIG_W-1:0] keep_mask,
  input  logic [SIG_W-1:0] unit,
  input  logic             lsb,
  input  logic             guard,
  input  logic             sticky,
  output logic [SIG_W-1:0] res,
  output logic             carry,
  output logic             inexact
);
  logic            inc;
  logic [SIG_W:0]  sum;

  always_comb begin
    inexact = guard | sticky;
    unique case (rmode)
      RM_NEAREST: inc = guard & (sticky | lsb);
      RM_DOWN:    inc = inexact & sign;
      RM_UP:      inc = inexact & ~sign;
      default:    inc = 1'b0;
    endcase
    sum   = {1'b0, sig & keep_mask} + (inc ? {1'b0, unit} : {(SIG_W+1){1'b0}});
    carry = sum[SIG_W];
    res   = carry ? {1'b1, {(SIG_W-1){1'b0}}} : sum[SIG_W-1:0];
  end
endmodule

// File: rtl/sig_round_unit.sv
module sig_round_unit
  import rnd_pkg::*;
#(
  parameter int unsigned SIG_W    = 64,
  parameter int unsigned SGL_BITS = 24,
  parameter int unsigned DBL_BITS = 53,
  parameter int unsigned CW_W     = 16,
  parameter int unsigned MASK_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_wr_en,
  input  logic [CW_W-1:0]   cw_wr_data,
  output logic [CW_W-1:0]   cw_q,
  output logic [MASK_W-1:0] exc_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sign,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic              in_guard,
  input  logic              in_round,
  input  logic              in_sticky,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SIG_W-1:0]  out_sig,
  output logic              out_carry,
  output logic              out_inexact
);
  rmode_e rmode;
  pcode_e pcode;

  rnd_ctrl_reg #(.CW_W(CW_W), .MASK_W(MASK_W)) u_cw (
    .clk(clk), .rst_n(rst_n), .wr_en(cw_wr_en), .wr_data(cw_wr_data),
    .cw(cw_q), .rmode(rmode), .pcode(pcode), .masks(exc_mask)
  );

  logic [SIG_W-1:0] km   [N_PREC];
  logic [SIG_W-1:0] un   [N_PREC];
  logic             lb   [N_PREC];
  logic             gd   [N_PREC];
  logic             sk   [N_PREC];

  generate
    for (genvar i = 0; i < N_PREC; i++) begin : g_prec
      localparam int unsigned KB = (i == 0) ? SGL_BITS : (i == 1) ? DBL_BITS : SIG_W;
      rnd_tail_extract #(.SIG_W(SIG_W), .KEEP(KB)) u_tail (
        .sig(in_sig), .g_in(in_guard), .r_in(in_round), .s_in(in_sticky),
        .keep_mask(km[i]), .unit(un[i]), .lsb(lb[i]), .guard(gd[i]), .sticky(sk[i])
      );
    end
  endgenerate

  int unsigned      sel;
  logic [SIG_W-1:0] res_d;
  logic             carry_d, inexact_d;

  assign sel = prec_index(pcode);

  rnd_round_core #(.SIG_W(SIG_W)) u_core (
    .sign(in_sign), .rmode(rmode), .sig(in_sig),
    .keep_mask(km[sel]), .unit(un[sel]), .lsb(lb[sel]),
    .guard(gd[sel]), .sticky(sk[sel]),
    .res(res_d), .carry(carry_d), .inexact(inexact_d)
  );

  // single output stage, back-pressure passes straight through
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sig     <= '0;
      out_carry   <= 1'b0;
      out_inexact <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sig     <= res_d;
        out_carry   <= carry_d;
        out_inexact <= inexact_d;
      end
    end
  end
endmodule

// File: rtl/rnd_checker.sv
module rnd_checker #(
  parameter int unsigned SIG_W    = 64,
  parameter int unsigned SGL_BITS = 24,
  parameter int unsigned CW_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW_W-1:0]  cw_q,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_guard,
  input logic             in_round,
  input logic             in_sticky,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SIG_W-1:0] out_sig,
  input logic             out_carry,
  input logic             out_inexact
);
  localparam int unsigned SGL_DROP = SIG_W - SGL_BITS;

  p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sig)
                                   && $stable(out_carry) && $stable(out_inexact)));

  p_carry_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_carry) |-> (out_sig == {1'b1, {(SIG_W-1){1'b0}}}));

  p_single_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cw_q[9:8] == 2'b00) |=> (out_sig[SGL_DROP-1:0] == '0));

  p_exact_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cw_q[9] == cw_q[8] && cw_q[8]
     && !in_guard && !in_round && !in_sticky) |=> !out_inexact);
endmodule

bind sig_round_unit rnd_checker #(.SIG_W(SIG_W), .SGL_BITS(SGL_BITS), .CW_W(CW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cw_q(cw_q), .in_valid(in_valid), .in_ready(in_ready),
  .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
  .out_valid(out_valid), .out_ready(out_ready), .out_sig(out_sig),
  .out_carry(out_carry), .out_inexact(out_inexact)
);

// File: tb/tb_sig_round_unit.sv
module tb_sig_round_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_wr_en = 1'b0;
  logic [15:0] cw_wr_data = '0;
  logic [15:0] cw_q;
  logic [5:0]  exc_mask;
  logic        in_valid = 1'b0, in_ready;
  logic        in_sign = 1'b0;
  logic [63:0] in_sig = '0;
  logic        in_guard = 1'b0, in_round = 1'b0, in_sticky = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [63:0] out_sig;
  logic        out_carry, out_inexact;

  sig_round_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic sign; logic [63:0] sig; logic g, r, s; logic [15:0] cw;
  } stim_t;
  typedef struct {
    logic [63:0] sig; logic carry, ix; logic [15:0] cw; logic [63:0] lowmask;
  } exp_t;

  stim_t stim_q[$];
  exp_t  exp_q[$];
  int checks = 0, errors = 0;

  function automatic int prec_of(input logic [1:0] pc);
    return (pc == 2'b00) ? 24 : (pc == 2'b10) ? 53 : 64;
  endfunction

  function automatic logic [15:0] mk_cw(input logic [1:0] rm, input logic [1:0] pc,
                                        input logic b12, input logic [5:0] m);
    return {3'b000, b12, rm, pc, 2'b01, m};
  endfunction

  // behavioural reference: compare the discarded tail against one half
  function automatic exp_t model(input stim_t st);
    exp_t e;
    int p, sh;
    logic [66:0] ext, lowm, low, half;
    logic [64:0] kept;
    logic inc;
    p    = prec_of(st.cw[9:8]);
    sh   = 64 - p;
    ext  = {st.sig, st.g, st.r, st.s};
    lowm = (67'd1 << (sh + 3)) - 67'd1;
    low  = ext & lowm;
    half = 67'd1 << (sh + 2);
    e.ix = (low != 0);
    kept = {1'b0, st.sig >> sh};
    case (st.cw[11:10])
      2'b00: inc = (low > half) || (low == half && kept[0]);
      2'b01: inc = e.ix && st.sign;
      2'b10: inc = e.ix && !st.sign;
      default: inc = 1'b0;
    endcase
    kept = kept + 65'(inc);
    e.carry = kept[p];
    e.sig   = e.carry ? 64'h8000_0000_0000_0000 : (kept[63:0] << sh);
    e.cw    = st.cw;
    e.lowmask = (sh == 0) ? 64'd0 : ((64'd1 << sh) - 64'd1);
    return e;
  endfunction

  function automatic string tag_of(input exp_t e);
    if (e.carry)                 return "R9";
    if (e.cw[12])                return "R10";
    if (e.cw[9:8] == 2'b01)      return "R4";
    if (e.cw[11:10] == 2'b00)    return "R6";
    if (e.cw[11:10] == 2'b11)    return "R3";
    return "R7";
  endfunction

  task automatic add(input logic sg, input logic [63:0] sv, input logic g, r, s,
                     input logic [15:0] cw);
    stim_t st;
    st.sign = sg; st.sig = sv; st.g = g; st.r = r; st.s = s; st.cw = cw;
    stim_q.push_back(st);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // directed corner cases
  initial begin
    for (int pci = 0; pci < 4; pci++) begin
      logic [1:0] pc;
      int sh;
      logic [63:0] base, halfbit;
      pc = 2'(pci);
      sh = 64 - prec_of(pc);
      base = 64'hC3A5_96F0_5A3C_E781 & ~((sh == 0) ? 64'd0 : ((64'd1 << sh) - 64'd1));
      halfbit = (sh == 0) ? 64'd0 : (64'd1 << (sh - 1));
      // R9 all ones carry, R3 chop never increments
      add(1'b0, '1, 1'b1, 1'b0, 1'b0, mk_cw(2'b00, pc, 1'b0, 6'h3F));
      add(1'b0, '1, 1'b1, 1'b1, 1'b1, mk_cw(2'b10, pc, 1'b0, 6'h3F));
      add(1'b1, '1, 1'b0, 1'b0, 1'b1, mk_cw(2'b01, pc, 1'b0, 6'h3F));
      add(1'b0, '1, 1'b1, 1'b1, 1'b1, mk_cw(2'b11, pc, 1'b0, 6'h3F));
      // R6 ties: even LSB stays, odd LSB rounds up
      for (int odd = 0; odd < 2; odd++) begin
        logic [63:0] v;
        v = base & ~(64'd1 << sh);
        if (odd != 0) v = v | (64'd1 << sh);
        if (sh == 0) add(1'b0, v, 1'b1, 1'b0, 1'b0, mk_cw(2'b00, pc, 1'b0, 6'h3F));
        else         add(1'b0, v | halfbit, 1'b0, 1'b0, 1'b0, mk_cw(2'b00, pc, 1'b0, 6'h3F));
        // just above half
        add(1'b1, v | halfbit, 1'b0, 1'b0, 1'b1, mk_cw(2'b00, pc, 1'b0, 6'h3F));
      end
      // R8 exact inputs in every mode, both signs
      for (int rm = 0; rm < 4; rm++)
        for (int sg = 0; sg < 2; sg++) begin
          add(sg[0], base, 1'b0, 1'b0, 1'b0, mk_cw(2'(rm), pc, 1'b0, 6'h15));
          // R7 smallest inexact tail
          add(sg[0], base, 1'b0, 1'b0, 1'b1, mk_cw(2'(rm), pc, 1'b0, 6'h2A));
        end
      // R10 bit 12 set on same operands
      add(1'b0, base | halfbit, 1'b1, 1'b0, 1'b0, mk_cw(2'b00, pc, 1'b1, 6'h3F));
      add(1'b1, base, 1'b0, 1'b1, 1'b0, mk_cw(2'b01, pc, 1'b1, 6'h00));
    end
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] rm, pc;
      logic [63:0] v;
      rm = 2'($urandom);
      pc = 2'($urandom);
      v  = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) v = v | 64'hFFFF_FFFF_FFFF_FF00;
      add(1'($urandom), v, 1'($urandom), 1'($urandom), 1'($urandom),
          mk_cw(rm, pc, 1'($urandom), 6'($urandom)));
    end
  end

  logic [15:0] cw_model = 16'h037F;
  bit          wrote_prev = 1'b0;
  bit          stall_prev = 1'b0;
  logic [63:0] prev_sig;
  logic        prev_carry, prev_ix;

  initial begin
    int cyc;
    cyc = 0;
    repeat (3) @(negedge clk);
    // R12 and R1 reset state, R2 mask reset
    chk(out_valid == 1'b0, "R12", 64'(out_valid), 64'd0);
    chk(cw_q == 16'h037F, "R1", 64'(cw_q), 64'h037F);
    chk(exc_mask == 6'h3F, "R2", 64'(exc_mask), 64'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", 64'(out_valid), 64'd0);
    chk(cw_q[12] == 1'b0, "R1", 64'(cw_q[12]), 64'd0);
    forever begin
      @(negedge clk);
      cyc++;
      // drive
      out_ready = ($urandom_range(0, 9) < 7);
      cw_wr_en  = 1'b0;
      in_valid  = 1'b0;
      if (stim_q.size() > 0) begin
        if (stim_q[0].cw != cw_model) begin
          cw_wr_en   = 1'b1;
          cw_wr_data = stim_q[0].cw;
        end else if ($urandom_range(0, 4) != 0) begin
          in_valid  = 1'b1;
          in_sign   = stim_q[0].sign;
          in_sig    = stim_q[0].sig;
          in_guard  = stim_q[0].g;
          in_round  = stim_q[0].r;
          in_sticky = stim_q[0].s;
        end
      end
      #1;
      // control register readback after a write
      if (wrote_prev) begin
        chk(cw_q == cw_model, "R1", 64'(cw_q), 64'(cw_model));
        chk(exc_mask == cw_model[5:0], "R2", 64'(exc_mask), 64'(cw_model[5:0]));
      end
      // R11 held result while stalled
      if (stall_prev) begin
        chk(out_valid && out_sig == prev_sig && out_carry == prev_carry
            && out_inexact == prev_ix, "R11", out_sig, prev_sig);
      end
      chk(in_ready == (!out_valid || out_ready), "R11", 64'(in_ready),
          64'(!out_valid || out_ready));
      stall_prev = out_valid && !out_ready;
      prev_sig = out_sig; prev_carry = out_carry; prev_ix = out_inexact;
      // output transfer
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", out_sig, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(out_sig == e.sig, tag_of(e), out_sig, e.sig);
          chk(out_carry == e.carry, "R9", 64'(out_carry), 64'(e.carry));
          chk(out_inexact == e.ix, "R8", 64'(out_inexact), 64'(e.ix));
          chk((out_sig & e.lowmask) == 64'd0, "R5", out_sig & e.lowmask, 64'd0);
        end
      end
      // input transfer
      if (in_valid && in_ready) begin
        exp_q.push_back(model(stim_q[0]));
        void'(stim_q.pop_front());
      end
      wrote_prev = cw_wr_en;
      if (cw_wr_en) cw_model = cw_wr_data;
      if (stim_q.size() == 0 && exp_q.size() == 0 && !out_valid) break;
      if (cyc > WATCHDOG) begin
        chk(1'b0, "watchdog", 64'(cyc), 64'(WATCHDOG));
        break;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule